// File: doc/BRIEF.md
# Bus Master Write Data Driver

This unit sits on the master side of a pipelined address/data bus and turns one write request into one single-beat write transfer. A requester offers an address, a size code and a right-justified data value. The unit checks that the address is naturally aligned for the size. It then drives an address phase and a data phase, and reports a completion status taken from the slave's response.

Narrow data is never shifted into one lane. A byte is copied into all four byte lanes and a halfword into both halves of the 32-bit bus. The lane a slave picks therefore does not depend on the byte order it uses. Once the data phase starts, the write data holds its value through every wait state the slave inserts, up to the cycle in which the slave reports ready.

The request side is a valid/ready stream. `req_ready` is high only while no transfer is in flight. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the requester must hold or repeat its request, and the unit ignores `req_valid`. Completion is a one-cycle `done` pulse carrying `status`. The `done` output cannot be back-pressured.

Top module: `mst_wr_driver`

## Requirements
- R1: After reset `req_ready` is 1, `htrans` is 00 (idle), `hwrite` is 0 and `done` is 0.
- R2: For a byte request (size code 00) the 32-bit write data is four copies of data bits [7:0], so 0x12 is driven as 0x12121212.
- R3: For a halfword request (size code 01) the write data is two copies of data bits [15:0], so 0x1234 is driven as 0x12341234. A word request (size code 10) drives the data unchanged.
- R4: Through every data-phase cycle with `hready` low, `hwdata` keeps the value it had when the data phase began, up to and including the cycle where `hready` is high.
- R5: A request is misaligned when it is a word with address bits [1:0] not equal to 00, a halfword with address bit 0 equal to 1, or uses size code 11. Such a request is still accepted. In the next cycle `done` is 1 with `status` 01 (error), and `htrans` stays 00, so no bus transfer is issued.
- R6: `req_ready` is 1 only while no transfer is in flight. From the accepting edge of an aligned request until `done`, `req_ready` is 0 and `req_valid` has no effect on the bus outputs.
- R7: `done` pulses for exactly one cycle. It rises in the cycle after the data-phase cycle in which `hready` is 1, and `status` then equals the `hresp` sampled in that cycle. `done` stays 0 while the data phase is extended.
- R8: In the cycle after an aligned request is accepted, the address phase starts. It drives `htrans` 10 (non-sequential), `hwrite` 1, `haddr` equal to the request address and `hsize` equal to {0, size code}. All of these hold while `hready` is 0, and the data phase begins on the first edge with `hready` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | 32 | Byte address of the write |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 illegal |
| req_data | input | 32 | Right-justified write value |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | 00 idle, 10 non-sequential |
| hwrite | output | 1 | Write indicator during the address phase |
| hsize | output | 3 | Transfer size: 000, 001 or 010 |
| hwdata | output | 32 | Lane-replicated write data |
| hready | input | 1 | Slave ready: the current phase ends |
| hresp | input | 2 | Slave response: 00 okay, 01 error, 10 retry, 11 split |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion status: slave response or local 01 |

## Verification
The hardest case to reach is a non-okay response that arrives at the end of a long data-phase stall, while the requester is already offering the next request. The bench holds `hready` low for a random number of data cycles and raises the chosen response in the last low cycle. It keeps `req_valid` high with altered fields during the address-phase stall, then checks that the bus outputs never move and that the status matches the response. Misaligned and illegal-size requests are mixed into the same random stream, so local rejection is exercised right next to real transfers.

// File: rtl/mst_wr_pkg.sv
package mst_wr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10
  } phase_t;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] RESP_OKAY    = 2'b00;
  localparam logic [1:0] RESP_ERROR   = 2'b01;
endpackage

// File: rtl/wr_align_check.sv
module wr_align_check #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              legal
);
  localparam int MAX_SIZE = $clog2(LANES);

  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    low_mask = ({{(ADDR_W-1){1'b0}}, 1'b1} << size) - 1'b1;
    legal    = (int'(size) <= MAX_SIZE) && ((addr & low_mask) == '0);
  end
endmodule

// File: rtl/wr_lane_replicate.sv
module wr_lane_replicate #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] data_in,
  input  logic [1:0]         size,
  output logic [LANES*8-1:0] data_out
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0] lane_mask;

  always_comb lane_mask = LW'((32'd1 << size) - 32'd1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] src;
    assign src = LW'(g) & lane_mask;
    assign data_out[g*8 +: 8] = data_in[src*8 +: 8];
  end
endmodule

// File: rtl/wr_phase_ctrl.sv
module wr_phase_ctrl
  import mst_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       legal,
  input  logic       hready,
  input  logic [1:0] hresp,
  output phase_t     phase,
  output logic       idle,
  output logic       done,
  output logic [1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      done   <= 1'b0;
      status <= RESP_OKAY;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            if (legal) begin
              phase <= PH_ADDR;
            end else begin
              done   <= 1'b1;
              status <= RESP_ERROR;
            end
          end
        end
        PH_ADDR: if (hready) phase <= PH_DATA;
        PH_DATA: begin
          if (hready) begin
            phase  <= PH_IDLE;
            done   <= 1'b1;
            status <= hresp;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign idle = (phase == PH_IDLE);
endmodule

// File: rtl/mst_wr_driver.sv
module mst_wr_driver
  import mst_wr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_data,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic [1:0]        hresp,
  output logic              done,
  output logic [1:0]        status
);
  localparam int LANES = DATA_W / 8;

  phase_t            phase;
  logic              idle;
  logic              accept;
  logic              legal;
  logic              in_data;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready = idle;
  assign accept    = req_valid & idle;

  wr_align_check #(.ADDR_W(ADDR_W), .LANES(LANES)) u_align (
    .addr  (req_addr),
    .size  (req_size),
    .legal (legal)
  );

  wr_phase_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .legal  (legal),
    .hready (hready),
    .hresp  (hresp),
    .phase  (phase),
    .idle   (idle),
    .done   (done),
    .status (status)
  );

  // Request fields are captured only for transfers that reach the bus.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= '0;
      data_q <= '0;
    end else if (accept && legal) begin
      addr_q <= req_addr;
      size_q <= req_size;
      data_q <= req_data;
    end
  end

  wr_lane_replicate #(.LANES(LANES)) u_rep (
    .data_in  (data_q),
    .size     (size_q),
    .data_out (hwdata)
  );

  assign in_data = (phase == PH_DATA);
  assign haddr   = addr_q;
  assign htrans  = (phase == PH_ADDR) ? TRANS_NONSEQ : TRANS_IDLE;
  assign hwrite  = (phase == PH_ADDR);
  assign hsize   = {1'b0, size_q};
endmodule

// File: rtl/mst_wr_driver_chk.sv
module mst_wr_driver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic [1:0]  req_size,
  input logic [31:0] haddr,
  input logic [1:0]  htrans,
  input logic [2:0]  hsize,
  input logic [31:0] hwdata,
  input logic        hready,
  input logic [1:0]  hresp,
  input logic        done,
  input logic [1:0]  status,
  input logic        in_data
);
  logic bad_req;
  assign bad_req = (req_size == 2'b11) ||
                   (req_size == 2'b10 && req_addr[1:0] != 2'b00) ||
                   (req_size == 2'b01 && req_addr[0]);

  a_r2_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    in_data && hsize == 3'b000 |->
      hwdata[31:24] == hwdata[7:0] && hwdata[23:16] == hwdata[7:0] && hwdata[15:8] == hwdata[7:0]);

  a_r3_half_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    in_data && hsize == 3'b001 |-> hwdata[31:16] == hwdata[15:0]);

  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_data && !hready |=> in_data && $stable(hwdata));

  a_r5_reject_local: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && bad_req |=> htrans == 2'b00 && done && status == 2'b01);

  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00 || in_data) |-> !req_ready);

  a_r7_status_capture: assert property (@(posedge clk) disable iff (!rst_n)
    in_data && hready |=> done && status == $past(hresp));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(req_valid && req_ready));

  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b10 && !hready |=> htrans == 2'b10 && $stable(haddr) && $stable(hsize));
endmodule

bind mst_wr_driver mst_wr_driver_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .haddr     (haddr),
  .htrans    (htrans),
  .hsize     (hsize),
  .hwdata    (hwdata),
  .hready    (hready),
  .hresp     (hresp),
  .done      (done),
  .status    (status),
  .in_data   (in_data)
);

// File: tb/mst_wr_driver_bench.sv
`timescale 1ns/1ps
module mst_wr_driver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_data = '0;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [31:0] hwdata;
  logic        hready = 1'b1;
  logic [1:0]  hresp = 2'b00;
  logic        done;
  logic [1:0]  status;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  mst_wr_driver u_mst_wr_driver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_data(req_data),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .hwdata(hwdata), .hready(hready), .hresp(hresp), .done(done), .status(status)
  );

  function automatic logic [31:0] exp_lanes(input logic [31:0] d, input logic [1:0] s);
    case (s)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic bit is_legal(input logic [31:0] a, input logic [1:0] s);
    case (s)
      2'b00:   return 1'b1;
      2'b01:   return a[0] == 1'b0;
      2'b10:   return a[1:0] == 2'b00;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge where completion is visible.
  task automatic xfer(input logic [31:0] a, input logic [1:0] s, input logic [31:0] d,
                      input int wa, input int wd, input logic [1:0] rsp);
    logic [31:0] ev;
    string       lane_tag;
    ev       = exp_lanes(d, s);
    lane_tag = (s == 2'b00) ? "R2" : "R3";
    req_valid = 1'b1; req_addr = a; req_size = s; req_data = d;
    check(req_ready == 1'b1, "R6 ready when idle", {31'b0, req_ready}, 32'd1);
    step();
    req_valid = 1'b0;
    if (!is_legal(a, s)) begin
      check(done && status == 2'b01, "R5 local error", {30'b0, status}, 32'd1);
      check(htrans == 2'b00, "R5 no transfer", {30'b0, htrans}, 32'd0);
      return;
    end
    check(htrans == 2'b10 && hwrite && hsize == {1'b0, s}, "R8 address phase",
          {27'b0, hsize, htrans}, {27'b0, 1'b0, s, 2'b10});
    check(haddr == a, "R8 address", haddr, a);
    for (int k = 0; k < wa; k++) begin
      hready = 1'b0;
      req_valid = 1'b1; req_addr = ~a; req_size = 2'b00; req_data = ~d;
      step();
      check(htrans == 2'b10 && haddr == a, "R8 address hold", haddr, a);
      check(!req_ready, "R6 busy not ready", {31'b0, req_ready}, 32'd0);
    end
    req_valid = 1'b0;
    hready = 1'b1;
    step();
    check(hwdata == ev, lane_tag, hwdata, ev);
    check(!done && htrans == 2'b00, "R7 no early done", {31'b0, done}, 32'd0);
    for (int k = 0; k < wd; k++) begin
      hready = 1'b0;
      hresp  = (k == wd - 1) ? rsp : 2'b00;
      step();
      check(hwdata == ev, "R4 data held in wait", hwdata, ev);
      check(!done, "R7 done low while stalled", {31'b0, done}, 32'd0);
    end
    hready = 1'b1;
    hresp  = rsp;
    step();
    hresp = 2'b00;
    check(done && status == rsp, "R7 status from response", {30'b0, status}, {30'b0, rsp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && htrans == 2'b00 && !hwrite && !done, "R1 reset state",
          {28'b0, req_ready, htrans, done}, {28'b0, 1'b1, 2'b00, 1'b0});

    xfer(32'h0000_1003, 2'b00, 32'hAABB_CC12, 0, 0, 2'b00);
    xfer(32'h0000_2002, 2'b01, 32'hFFFF_1234, 1, 2, 2'b00);
    xfer(32'h0000_3000, 2'b10, 32'hDEAD_BEEF, 2, 5, 2'b01);
    xfer(32'h0000_3002, 2'b10, 32'h1111_2222, 0, 0, 2'b00);
    xfer(32'h0000_3001, 2'b01, 32'h3333_4444, 0, 0, 2'b00);
    xfer(32'h0000_3000, 2'b11, 32'h5555_6666, 0, 0, 2'b00);
    xfer(32'h0000_4004, 2'b10, 32'h0BAD_F00D, 3, 1, 2'b10);
    xfer(32'h0000_4006, 2'b01, 32'hCAFE_00AB, 0, 1, 2'b11);
    @(negedge clk);
    check(!done, "R7 single pulse", {31'b0, done}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [1:0]  s;
      logic [1:0]  r;
      int          wa;
      int          wd;
      s = 2'($urandom % 4);
      a = $urandom;
      if ($urandom % 4 != 0) a = a & ~32'h3;
      r = ($urandom % 2 == 0) ? 2'b00 : 2'($urandom % 4);
      wa = $urandom % 3;
      wd = $urandom % 4;
      if (r != 2'b00 && wd == 0) wd = 1;
      xfer(a, s, $urandom, wa, wd, r);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule